// File: doc/BRIEF.md
# Discrete-Log Modular Multiplier

This block multiplies two residues modulo a prime P without a multiplier array. Every nonzero residue modulo a prime is a power of a fixed primitive root g, so the block maps each nonzero operand to its exponent (its discrete logarithm) through a lookup table. It adds the two exponents modulo P-1 and maps the sum back through a power table. Both tables are computed when the design is elaborated, from the parameters P and g.

The second operand can also arrive already in exponent form. This suits filter coefficients that are stored as exponents, because it removes one table lookup from the path. An exponent cannot encode zero, so in that mode a separate flag marks a zero coefficient. A zero operand in either form skips the exponent path and forces the product to zero. The result is registered. A valid strobe loads it, and the output valid follows that strobe one cycle later.

Top module: `idxmul_top`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe seen yet, `prod_vld` is 0 and `prod_res` is 0.
- R2: `prod_vld` in a cycle equals `in_vld` of the previous cycle.
- R3: When `in_vld` is 1, `b_is_exp` is 0 and both `a_res` and `b_res` are nonzero residues below P, `prod_res` one cycle later equals (a_res*b_res) mod P.
- R4: When `in_vld` is 1 and `a_res` is 0, or `b_is_exp` is 0 and `b_res` is 0, `prod_res` one cycle later is 0.
- R5: When `in_vld` is 1, `b_is_exp` is 1 and `b_zero` is 0, the low $clog2(P-1) bits of `b_res` carry an exponent e below P-1. `prod_res` one cycle later equals (a_res * g^e) mod P, with g = ROOT.
- R6: When `in_vld` is 1, `b_is_exp` is 1 and `b_zero` is 1, `prod_res` one cycle later is 0, whatever `b_res` holds.
- R7: When `b_is_exp` is 0, `b_zero` has no effect on `prod_res`.
- R8: While `in_vld` is 0, `prod_res` keeps its value.
- R9: When the two exponents add up to P-1 or more, the sum wraps by subtracting P-1 once, so products whose exponents overflow are still correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands valid; loads the result register |
| a_res | input | $clog2(P) | First operand, a residue below P |
| b_res | input | $clog2(P) | Second operand: a residue, or an exponent in its low bits |
| b_is_exp | input | 1 | 1: `b_res` holds an exponent of g |
| b_zero | input | 1 | Zero marker for an exponent-form second operand |
| prod_res | output | $clog2(P) | Registered product modulo P |
| prod_vld | output | 1 | Product valid, one cycle after `in_vld` |

## Verification
The hardest case to reach is the wrap of the exponent sum, together with the case where the exponent tables would disagree with plain arithmetic. Only particular operand pairs produce these. The bench therefore applies every ordered pair of residues, zero included. It also applies every residue against every exponent in exponent form, and compares each result with a product computed independently in the bench. A wrong table entry or a wrong wrap rule cannot escape this sweep. Short directed cases then cover the zero flag, the flag being ignored in residue form, and the hold behaviour.

// File: rtl/idxmul_pkg.sv
package idxmul_pkg;
  // g^e mod m by repeated multiplication, for elaboration-time tables
  function automatic int pow_mod(int base, int e, int m);
    int r;
    r = 1 % m;
    for (int k = 0; k < e; k++) r = (r * base) % m;
    return r;
  endfunction
endpackage

// File: rtl/idxmul_log_lut.sv
module idxmul_log_lut #(
  parameter int P    = 17,
  parameter int ROOT = 3,
  parameter int W    = $clog2(P),
  parameter int IW   = $clog2(P - 1)
) (
  input  logic [W-1:0]  res_i,
  output logic [IW-1:0] exp_o
);
  localparam int N = P - 1;

  // entry (r-1) holds the exponent e with ROOT^e mod P == r
  function automatic logic [N*IW-1:0] build_log();
    logic [N*IW-1:0] t;
    int r;
    t = '0;
    for (int k = 0; k < N; k++) begin
      r = idxmul_pkg::pow_mod(ROOT, k, P);
      t[(r-1)*IW +: IW] = IW'(k);
    end
    return t;
  endfunction

  localparam logic [N*IW-1:0] LOG_TBL = build_log();

  always_comb begin
    exp_o = '0;
    for (int r = 1; r < P; r++)
      if (res_i == W'(r)) exp_o = LOG_TBL[(r-1)*IW +: IW];
  end
endmodule

// File: rtl/idxmul_exp_lut.sv
module idxmul_exp_lut #(
  parameter int P    = 17,
  parameter int ROOT = 3,
  parameter int W    = $clog2(P),
  parameter int IW   = $clog2(P - 1)
) (
  input  logic [IW-1:0] exp_i,
  output logic [W-1:0]  res_o
);
  localparam int N = P - 1;

  function automatic logic [N*W-1:0] build_pow();
    logic [N*W-1:0] t;
    t = '0;
    for (int k = 0; k < N; k++)
      t[k*W +: W] = W'(idxmul_pkg::pow_mod(ROOT, k, P));
    return t;
  endfunction

  localparam logic [N*W-1:0] POW_TBL = build_pow();

  always_comb begin
    res_o = '0;
    for (int k = 0; k < N; k++)
      if (exp_i == IW'(k)) res_o = POW_TBL[k*W +: W];
  end
endmodule

// File: rtl/idxmul_exp_add.sv
module idxmul_exp_add #(
  parameter int P  = 17,
  parameter int IW = $clog2(P - 1)
) (
  input  logic [IW-1:0] ea_i,
  input  logic [IW-1:0] eb_i,
  output logic [IW-1:0] sum_o
);
  localparam logic [IW:0] ORD = (IW+1)'(P - 1);

  logic [IW:0] raw;

  always_comb begin
    raw   = {1'b0, ea_i} + {1'b0, eb_i};
    sum_o = (raw >= ORD) ? IW'(raw - ORD) : raw[IW-1:0];
  end

  // R9: a wrapped sum of in-range exponents stays below the group order
  always_comb begin
    if ({1'b0, ea_i} < ORD && {1'b0, eb_i} < ORD)
      a_sum_range_r9: assert ({1'b0, sum_o} < ORD);
  end
endmodule

// File: rtl/idxmul_top.sv
module idxmul_top #(
  parameter int P    = 17,
  parameter int ROOT = 3,
  parameter int W    = $clog2(P),
  parameter int IW   = $clog2(P - 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] a_res,
  input  logic [W-1:0] b_res,
  input  logic         b_is_exp,
  input  logic         b_zero,
  output logic [W-1:0] prod_res,
  output logic         prod_vld
);
  logic [IW-1:0] a_exp, b_exp_lut, b_exp, exp_sum;
  logic [W-1:0]  pow_res;
  logic          a_is_zero, b_is_zero;
  logic [W-1:0]  res_d, res_q;
  logic          vld_d, vld_q;

  idxmul_log_lut #(.P(P), .ROOT(ROOT), .W(W), .IW(IW)) u_log_a (
    .res_i(a_res), .exp_o(a_exp));

  idxmul_log_lut #(.P(P), .ROOT(ROOT), .W(W), .IW(IW)) u_log_b (
    .res_i(b_res), .exp_o(b_exp_lut));

  idxmul_exp_add #(.P(P), .IW(IW)) u_add (
    .ea_i(a_exp), .eb_i(b_exp), .sum_o(exp_sum));

  idxmul_exp_lut #(.P(P), .ROOT(ROOT), .W(W), .IW(IW)) u_pow (
    .exp_i(exp_sum), .res_o(pow_res));

  // operand selection and zero bypass
  always_comb begin
    b_exp     = b_is_exp ? b_res[IW-1:0] : b_exp_lut;
    a_is_zero = (a_res == '0);
    b_is_zero = b_is_exp ? b_zero : (b_res == '0);
  end

  // next state
  always_comb begin
    res_d = res_q;
    if (in_vld) res_d = (a_is_zero || b_is_zero) ? '0 : pow_res;
    vld_d = in_vld;
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign prod_res = res_q;
  assign prod_vld = vld_q;

  p_vld_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> prod_vld);
  p_vld_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !prod_vld);
  p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !b_is_exp && a_res != '0 && b_res != '0 &&
     a_res < W'(P) && b_res < W'(P)) |=> (prod_res != '0));
  p_zero_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && a_res == '0) |=> (prod_res == '0));
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && b_is_exp && b_zero) |=> (prod_res == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(prod_res));
endmodule

// File: tb/sim_idxmul_top.sv
`timescale 1ns/1ps
module sim_idxmul_top;
  localparam int P    = 17;
  localparam int ROOT = 3;
  localparam int W    = $clog2(P);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [W-1:0] a_res = '0;
  logic [W-1:0] b_res = '0;
  logic         b_is_exp = 1'b0;
  logic         b_zero = 1'b0;
  logic [W-1:0] prod_res;
  logic         prod_vld;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idxmul_top #(.P(P), .ROOT(ROOT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a_res(a_res), .b_res(b_res),
    .b_is_exp(b_is_exp), .b_zero(b_zero), .prod_res(prod_res), .prod_vld(prod_vld));

  function automatic int gpow(int e);
    int r;
    r = 1;
    for (int k = 0; k < e; k++) r = (r * ROOT) % P;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one operation at a falling edge; the result is read at the next one
  task automatic apply(input int a, input int b, input bit isexp, input bit z);
    @(negedge clk);
    a_res = W'(a); b_res = W'(b); b_is_exp = isexp; b_zero = z; in_vld = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 vld in reset", int'(prod_vld), 0);
    chk("R1 res in reset", int'(prod_res), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vld after release", int'(prod_vld), 0);
    chk("R1 res after release", int'(prod_res), 0);
  endtask

  // R3, R4, R9: every ordered residue pair
  task automatic t_all_pairs();
    for (int a = 0; a < P; a++)
      for (int b = 0; b < P; b++) begin
        apply(a, b, 1'b0, 1'b0);
        if (a == 0 || b == 0) chk("R4 zero operand", int'(prod_res), 0);
        else chk("R3/R9 residue product", int'(prod_res), (a * b) % P);
        chk("R2 vld with strobe", int'(prod_vld), 1);
      end
    in_vld = 1'b0;
  endtask

  // R5, R9: second operand given as exponent
  task automatic t_exp_form();
    for (int a = 0; a < P; a++)
      for (int e = 0; e < P - 1; e++) begin
        apply(a, e, 1'b1, 1'b0);
        chk("R5 exponent-form product", int'(prod_res), (a * gpow(e)) % P);
      end
    in_vld = 1'b0;
  endtask

  // R6: zero flag forces zero whatever the exponent bits
  task automatic t_zero_flag();
    apply(5, 7, 1'b0, 1'b0);
    chk("R6 setup", int'(prod_res), 1);
    apply(5, 3, 1'b1, 1'b1);
    chk("R6 zero flag", int'(prod_res), 0);
    apply(16, 0, 1'b1, 1'b1);
    chk("R6 zero flag exp0", int'(prod_res), 0);
    in_vld = 1'b0;
  endtask

  // R7: flag ignored in residue form
  task automatic t_flag_ignored();
    apply(3, 5, 1'b0, 1'b1);
    chk("R7 flag ignored", int'(prod_res), 15);
    apply(16, 16, 1'b0, 1'b1);
    chk("R7 flag ignored wrap", int'(prod_res), 1);
    in_vld = 1'b0;
  endtask

  // R8 and R2: idle cycles keep the result and drop valid
  task automatic t_hold();
    apply(6, 6, 1'b0, 1'b0);
    chk("R9 wrap 6*6", int'(prod_res), 2);
    in_vld = 1'b0; a_res = W'(0); b_res = W'(9);
    @(negedge clk);
    chk("R2 vld drops", int'(prod_vld), 0);
    chk("R8 hold", int'(prod_res), 2);
    a_res = W'(4); b_is_exp = 1'b1; b_zero = 1'b1;
    @(negedge clk);
    chk("R8 hold second idle", int'(prod_res), 2);
    chk("R2 vld stays low", int'(prod_vld), 0);
  endtask

  initial begin
    t_reset();
    t_all_pairs();
    t_exp_form();
    t_zero_flag();
    t_flag_ignored();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule